// File: doc/BRIEF.md
# Morse Symbol Receiver Decoder

This block watches a 3-bit coded Morse symbol stream. A transmitter on the same clock produces the stream. The block collects the dots and dashes of the character currently being keyed in a shift register and keeps a length count beside it. A gap code closes the character. The collected pattern is then looked up and the matching 8-bit ASCII code is presented together with a single-cycle valid strobe.

The table holds the twenty-six letters, which decode to lowercase ASCII, and the ten digits, which use the five-symbol patterns. A gap between words with nothing collected produces an ASCII space. A pattern outside the table, or one longer than the table can hold, produces a question mark.

A symbol is counted when its code first appears, so the sender may hold a code for as many cycles as it likes. The reset is asynchronous and active-low.

Top module: `morse_rx_decoder`

## Requirements
- R1: The input code values are 0 idle, 1 dot, 2 dash, 3 character gap and 4 word gap. The codes 5, 6 and 7 are treated exactly like idle and never change the collected pattern or the output.
- R2: A dot or dash is counted once when its code differs from the code sampled on the previous clock edge. Holding the same code over several cycles adds no further symbol.
- R3: A letter's pattern decodes to its lowercase ASCII code (8'h61 'a' to 8'h7a 'z'). The pattern is taken first symbol first, with dot 0 and dash 1, so dot then dash gives 8'h61.
- R4: A five-symbol digit pattern decodes to 8'h30 through 8'h39. A run of k dots followed by dashes gives digit k, with five dashes giving 0. A run of k dashes followed by dots gives digit 5+k.
- R5: The valid strobe is high for exactly one cycle, the cycle after the clock edge that samples a new gap code, and the character output carries the decoded code in that cycle. The character output holds its last value until the next decode.
- R6: A word gap that arrives with no symbols collected outputs 8'h20 with a valid strobe.
- R7: A collected pattern that matches no table entry, or one holding more than five symbols, outputs 8'h3F.
- R8: A character gap that arrives with no symbols collected gives no valid strobe and leaves the character output unchanged.
- R9: After every gap the collected pattern and length are cleared, so the next character is decoded on its own.
- R10: While reset is low the valid strobe is 0 and the character output is 8'h00. Any partly collected pattern is discarded.
- R11: A word gap that arrives while symbols are collected outputs the decoded character rather than a space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_i | input | 3 | Coded symbol stream (R1 encoding) |
| char_o | output | 8 | Decoded ASCII character |
| char_vld_o | output | 1 | One-cycle strobe marking a new character |

## Verification
The bench builds the decoder with its defaults: a five-symbol limit, space 8'h20 and unknown 8'h3F. With the limit at five, a run of six dots reaches the saturated length count and so checks the over-length path. The same limit also puts every digit pattern at the longest length the table holds. Held codes, the ignored codes 5 to 7, and a character gap followed at once by a word gap exercise the change detector and two strobes in consecutive cycles.

// File: rtl/morse_rx_pkg.sv
package morse_rx_pkg;

   localparam int SYM_W  = 3;
   localparam int CHAR_W = 8;

   typedef enum logic [SYM_W-1:0] {
      SYM_IDLE = 3'd0,
      SYM_DOT  = 3'd1,
      SYM_DASH = 3'd2,
      SYM_CGAP = 3'd3,
      SYM_WGAP = 3'd4
   } sym_e;

   // Letter lookup: n symbols, pattern p first symbol in the MSB, dot 0, dash 1.
   // Returns 8'h00 when nothing matches.
   function automatic logic [CHAR_W-1:0] letter_of(input logic [2:0] n,
                                                   input logic [3:0] p);
      logic [CHAR_W-1:0] c;
      case ({n, p})
         {3'd1, 4'b0000}: c = 8'h65; // e
         {3'd1, 4'b0001}: c = 8'h74; // t
         {3'd2, 4'b0000}: c = 8'h69; // i
         {3'd2, 4'b0001}: c = 8'h61; // a
         {3'd2, 4'b0010}: c = 8'h6e; // n
         {3'd2, 4'b0011}: c = 8'h6d; // m
         {3'd3, 4'b0000}: c = 8'h73; // s
         {3'd3, 4'b0001}: c = 8'h75; // u
         {3'd3, 4'b0010}: c = 8'h72; // r
         {3'd3, 4'b0011}: c = 8'h77; // w
         {3'd3, 4'b0100}: c = 8'h64; // d
         {3'd3, 4'b0101}: c = 8'h6b; // k
         {3'd3, 4'b0110}: c = 8'h67; // g
         {3'd3, 4'b0111}: c = 8'h6f; // o
         {3'd4, 4'b0000}: c = 8'h68; // h
         {3'd4, 4'b0001}: c = 8'h76; // v
         {3'd4, 4'b0010}: c = 8'h66; // f
         {3'd4, 4'b0100}: c = 8'h6c; // l
         {3'd4, 4'b0110}: c = 8'h70; // p
         {3'd4, 4'b0111}: c = 8'h6a; // j
         {3'd4, 4'b1000}: c = 8'h62; // b
         {3'd4, 4'b1001}: c = 8'h78; // x
         {3'd4, 4'b1010}: c = 8'h63; // c
         {3'd4, 4'b1011}: c = 8'h79; // y
         {3'd4, 4'b1100}: c = 8'h7a; // z
         {3'd4, 4'b1101}: c = 8'h71; // q
         default:         c = 8'h00;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/morse_sym_edge.sv
module morse_sym_edge
   import morse_rx_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SYM_W-1:0] sym_i,
   output logic             mark_o,
   output logic             mark_bit_o,
   output logic             cend_o,
   output logic             wend_o
);

   logic [SYM_W-1:0] prev_q;
   logic             fresh;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= SYM_IDLE;
      else         prev_q <= sym_i;
   end

   assign fresh = (sym_i != prev_q);

   always_comb begin
      mark_o     = 1'b0;
      mark_bit_o = 1'b0;
      cend_o     = 1'b0;
      wend_o     = 1'b0;
      if (fresh) begin
         case (sym_i)
            SYM_DOT:  mark_o = 1'b1;
            SYM_DASH: begin mark_o = 1'b1; mark_bit_o = 1'b1; end
            SYM_CGAP: cend_o = 1'b1;
            SYM_WGAP: wend_o = 1'b1;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/morse_seq_accum.sv
module morse_seq_accum #(
   parameter int MAX_LEN = 5,
   parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               mark_i,
   input  logic               bit_i,
   input  logic               clear_i,
   output logic [MAX_LEN-1:0] seq_o,
   output logic [LEN_W-1:0]   len_o
);

   localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_LEN + 1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seq_o <= '0;
         len_o <= '0;
      end else if (clear_i) begin
         seq_o <= '0;
         len_o <= '0;
      end else if (mark_i) begin
         seq_o <= {seq_o[MAX_LEN-2:0], bit_i};
         if (len_o != LEN_SAT) len_o <= len_o + 1'b1;
      end
   end

endmodule

// File: rtl/morse_code_lut.sv
module morse_code_lut
   import morse_rx_pkg::*;
#(
   parameter int                MAX_LEN      = 5,
   parameter int                LEN_W        = $clog2(MAX_LEN + 2),
   parameter logic [CHAR_W-1:0] UNKNOWN_CODE = 8'h3F
) (
   input  logic [MAX_LEN-1:0] seq_i,
   input  logic [LEN_W-1:0]   len_i,
   output logic [CHAR_W-1:0]  code_o
);

   localparam int DIG_LEN = 5;

   logic       is_five;
   logic [5:0] dot_first_hit;   // k dots then dashes -> digit k
   logic [3:0] dash_first_hit;  // k dashes then dots -> digit 5+k
   logic [CHAR_W-1:0] letter;

   assign is_five = (len_i == LEN_W'(DIG_LEN));

   generate
      for (genvar k = 0; k <= 5; k++) begin : g_dot_first
         localparam logic [DIG_LEN-1:0] PAT = DIG_LEN'((1 << (DIG_LEN - k)) - 1);
         assign dot_first_hit[k] = is_five && (seq_i[DIG_LEN-1:0] == PAT);
      end
      for (genvar k = 1; k <= 4; k++) begin : g_dash_first
         localparam logic [DIG_LEN-1:0] PAT = DIG_LEN'(((1 << k) - 1) << (DIG_LEN - k));
         assign dash_first_hit[k-1] = is_five && (seq_i[DIG_LEN-1:0] == PAT);
      end
   endgenerate

   always_comb begin
      letter = 8'h00;
      if (len_i != '0 && len_i <= LEN_W'(4))
         letter = letter_of(len_i[2:0], seq_i[3:0]);
   end

   always_comb begin
      code_o = UNKNOWN_CODE;
      if (letter != 8'h00) code_o = letter;
      for (int k = 0; k <= 5; k++)
         if (dot_first_hit[k]) code_o = CHAR_W'(8'h30 + k);
      for (int k = 1; k <= 4; k++)
         if (dash_first_hit[k-1]) code_o = CHAR_W'(8'h35 + k);
   end

endmodule

// File: rtl/morse_rx_decoder.sv
module morse_rx_decoder
   import morse_rx_pkg::*;
#(
   parameter int                MAX_LEN      = 5,
   parameter logic [CHAR_W-1:0] SPACE_CODE   = 8'h20,
   parameter logic [CHAR_W-1:0] UNKNOWN_CODE = 8'h3F
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SYM_W-1:0]  sym_i,
   output logic [CHAR_W-1:0] char_o,
   output logic              char_vld_o
);

   localparam int LEN_W = $clog2(MAX_LEN + 2);

   generate
      if (MAX_LEN < 5) begin : g_bad_len
         $error("MAX_LEN must be at least 5 to hold the digit patterns");
      end
      if (LEN_W < 3) begin : g_bad_lenw
         $error("length counter too narrow");
      end
   endgenerate

   logic               mark, mark_bit, cend, wend;
   logic [MAX_LEN-1:0] seq;
   logic [LEN_W-1:0]   len;
   logic [CHAR_W-1:0]  lut_code;
   logic               gap, empty;

   morse_sym_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sym_i      (sym_i),
      .mark_o     (mark),
      .mark_bit_o (mark_bit),
      .cend_o     (cend),
      .wend_o     (wend)
   );

   assign gap   = cend | wend;
   assign empty = (len == '0);

   morse_seq_accum #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_accum (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mark_i  (mark),
      .bit_i   (mark_bit),
      .clear_i (gap),
      .seq_o   (seq),
      .len_o   (len)
   );

   morse_code_lut #(
      .MAX_LEN      (MAX_LEN),
      .LEN_W        (LEN_W),
      .UNKNOWN_CODE (UNKNOWN_CODE)
   ) u_lut (
      .seq_i  (seq),
      .len_i  (len),
      .code_o (lut_code)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         char_o     <= '0;
         char_vld_o <= 1'b0;
      end else begin
         char_vld_o <= 1'b0;
         if (wend && empty) begin
            char_o     <= SPACE_CODE;
            char_vld_o <= 1'b1;
         end else if (gap && !empty) begin
            char_o     <= lut_code;
            char_vld_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/morse_rx_checker.sv
module morse_rx_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [2:0] sym_i,
   input logic [7:0] char_o,
   input logic       char_vld_o
);

   p_vld_from_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      char_vld_o |-> ($past(sym_i) == 3'd3 || $past(sym_i) == 3'd4));

   p_idle_no_vld_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sym_i == 3'd0 || sym_i >= 3'd5) |=> !char_vld_o);

   p_held_no_vld_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && sym_i == $past(sym_i)) |=> !char_vld_o);

   p_space_from_wgap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (char_vld_o && char_o == 8'h20) |-> $past(sym_i) == 3'd4);

   p_char_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      char_vld_o |-> ((char_o >= 8'h61 && char_o <= 8'h7a) ||
                      (char_o >= 8'h30 && char_o <= 8'h39) ||
                      char_o == 8'h20 || char_o == 8'h3F));

   p_hold_char_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !char_vld_o) |-> $stable(char_o));

   p_reset_clear_r10: assert property (@(posedge clk_i)
      !rst_ni |-> (!char_vld_o && char_o == 8'h00));

endmodule

bind morse_rx_decoder morse_rx_checker u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .sym_i      (sym_i),
   .char_o     (char_o),
   .char_vld_o (char_vld_o)
);

// File: tb/tb_morse_rx_decoder.sv
`timescale 1ns/1ps
module tb_morse_rx_decoder;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [2:0] sym_i = 3'd0;
   logic [7:0] char_o;
   logic       char_vld_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk_i = ~clk_i;

   morse_rx_decoder dut (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sym_i      (sym_i),
      .char_o     (char_o),
      .char_vld_o (char_vld_o)
   );

   // {n[16:14], pattern[13:9] first symbol in bit n-1, word gap[8], expected[7:0]}
   localparam logic [16:0] VECS [16] = '{
      {3'd2, 5'b00001, 1'b0, 8'h61},  // a
      {3'd1, 5'b00000, 1'b0, 8'h65},  // e
      {3'd1, 5'b00001, 1'b0, 8'h74},  // t
      {3'd4, 5'b00000, 1'b0, 8'h68},  // h
      {3'd4, 5'b01101, 1'b0, 8'h71},  // q
      {3'd4, 5'b01100, 1'b0, 8'h7a},  // z
      {3'd3, 5'b00111, 1'b0, 8'h6f},  // o
      {3'd3, 5'b00101, 1'b0, 8'h6b},  // k
      {3'd5, 5'b11111, 1'b0, 8'h30},  // 0
      {3'd5, 5'b01111, 1'b0, 8'h31},  // 1
      {3'd5, 5'b00000, 1'b0, 8'h35},  // 5
      {3'd5, 5'b10000, 1'b0, 8'h36},  // 6
      {3'd5, 5'b11110, 1'b0, 8'h39},  // 9
      {3'd4, 5'b01011, 1'b1, 8'h79},  // y closed by word gap (R11)
      {3'd4, 5'b00011, 1'b0, 8'h3F},  // not in table (R7)
      {3'd5, 5'b01010, 1'b0, 8'h3F}   // five symbols, not a digit (R7)
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_bits(input int n, input logic [4:0] pat);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk_i) sym_i = pat[i] ? 3'd2 : 3'd1;
         @(negedge clk_i) sym_i = 3'd0;
      end
   endtask

   task automatic end_char(input logic word, input logic [7:0] exp, input string req);
      @(negedge clk_i) sym_i = word ? 3'd4 : 3'd3;
      @(negedge clk_i);
      check({req, " valid"}, {7'd0, char_vld_o}, 8'd1);
      check({req, " char"}, char_o, exp);
      sym_i = 3'd0;
      @(negedge clk_i);
      check({req, " valid drop"}, {7'd0, char_vld_o}, 8'd0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      check("R10 reset valid", {7'd0, char_vld_o}, 8'd0);
      check("R10 reset char", char_o, 8'h00);
      rst_ni = 1'b1;
      repeat (2) @(negedge clk_i);

      // table walk: R3, R4, R5, R7, R9, R11
      for (int v = 0; v < 16; v++) begin
         send_bits(int'(VECS[v][16:14]), VECS[v][13:9]);
         end_char(VECS[v][8], VECS[v][7:0], "R3/R4/R7/R9 vector");
      end

      // R2: held dot and held dash count once each
      @(negedge clk_i) sym_i = 3'd1;
      repeat (3) @(negedge clk_i);
      sym_i = 3'd0;
      @(negedge clk_i) sym_i = 3'd2;
      repeat (2) @(negedge clk_i);
      sym_i = 3'd0;
      end_char(1'b0, 8'h61, "R2 held symbols");

      // R2: dash then dash with no idle between counts once -> t
      @(negedge clk_i) sym_i = 3'd2;
      @(negedge clk_i) sym_i = 3'd2;
      @(negedge clk_i) sym_i = 3'd0;
      end_char(1'b0, 8'h74, "R2 repeated code");

      // R1: codes 5..7 ignored between symbols, no strobe
      @(negedge clk_i) sym_i = 3'd1;
      @(negedge clk_i) sym_i = 3'd5;
      @(negedge clk_i) sym_i = 3'd6;
      @(negedge clk_i);
      check("R1 ignored code valid", {7'd0, char_vld_o}, 8'd0);
      sym_i = 3'd2;
      @(negedge clk_i) sym_i = 3'd7;
      @(negedge clk_i) sym_i = 3'd0;
      end_char(1'b0, 8'h61, "R1 ignored codes");

      // R7: six dots overflow
      send_bits(5, 5'b00000);
      send_bits(1, 5'b00000);
      end_char(1'b0, 8'h3F, "R7 overflow");

      // R6: word gap with empty sequence
      end_char(1'b1, 8'h20, "R6 empty word gap");

      // R5/R6: character gap then word gap back to back -> e then space
      send_bits(1, 5'b00000);
      @(negedge clk_i) sym_i = 3'd3;
      @(negedge clk_i);
      check("R5 first strobe", {7'd0, char_vld_o}, 8'd1);
      check("R5 first char", char_o, 8'h65);
      sym_i = 3'd4;
      @(negedge clk_i);
      check("R6 second strobe", {7'd0, char_vld_o}, 8'd1);
      check("R6 second char", char_o, 8'h20);
      sym_i = 3'd0;
      @(negedge clk_i);
      check("R5 strobe ends", {7'd0, char_vld_o}, 8'd0);

      // R8: character gap with empty sequence
      @(negedge clk_i) sym_i = 3'd3;
      repeat (3) begin
         @(negedge clk_i);
         check("R8 no strobe", {7'd0, char_vld_o}, 8'd0);
      end
      check("R8 char held", char_o, 8'h20);
      sym_i = 3'd0;

      // R10: reset mid-character discards pattern
      send_bits(2, 5'b00001);
      @(negedge clk_i) rst_ni = 1'b0;
      @(negedge clk_i);
      check("R10 mid reset char", char_o, 8'h00);
      rst_ni = 1'b1;
      @(negedge clk_i) sym_i = 3'd3;
      @(negedge clk_i);
      check("R10 discarded pattern", {7'd0, char_vld_o}, 8'd0);
      sym_i = 3'd0;
      send_bits(1, 5'b00000);
      end_char(1'b0, 8'h65, "R10 R9 after reset");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule